// File: doc/BRIEF.md
# Scripted Scatter-Gather DMA Engine

This block is a small sequencer that walks a list of two-word instructions held in memory and carries out data moves between a local data FIFO and memory without help from the host. The host loads a start address into the script pointer. That write launches execution. The engine reads each instruction over a request/grant bus-master port, classifies its opcode and then either moves a block of words, stops with an interrupt, or stops with an error.

A block move runs in bursts. The burst size is chosen by a two-bit configuration input. Before each burst the engine checks the FIFO. For a move toward memory it waits until enough words are queued. For a move out of memory it waits until enough slots are free. Only then does it raise its bus request. It releases the bus after every burst and stays off it until the FIFO condition holds again. When a move finishes, the engine fetches the instruction that follows it. This lets a chain of moves scatter data to, or gather it from, many memory regions.

The peripheral side of the FIFO is exposed as plain push and pop ports.

Top module: `sg_dma_engine`

## Requirements
- R1: A pointer write while the engine is idle (not busy and no interrupt pending) raises `bus_req` on the next cycle as a read of length 2 at the written address. Pointer writes at other times are ignored.
- R2: An instruction is fetched as two consecutive 32-bit reads at the pointer and the pointer plus 4. Bits 31:24 of the first word are the opcode, and the second word is the move's memory start address.
- R3: An opcode in 0x00–0x3F moves FIFO words to memory with `mem_we` high. The first word's bits 23:2 give the number of whole words, and bits 1:0 of the byte count are dropped. Words are written to consecutive addresses in FIFO order.
- R4: An opcode in 0x40–0x7F reads consecutive memory words into the FIFO, where they appear at `pf_rdata` in address order.
- R5: `burst_sel` values 0, 1 and 2 or 3 select bursts of 4, 8 and 16 beats. The last burst of a move is cut to the words that remain. `mem_len` gives the beat count of the current request.
- R6: A burst to memory is requested only when the FIFO holds at least that burst's word count. A burst from memory is requested only when at least that many slots are free.
- R7: A beat is a cycle with `bus_req`, `bus_gnt` and `mem_ack` all high. Each beat advances `mem_addr` by 4. `bus_req` drops for at least one cycle after every burst and after every fetch.
- R8: A block move whose word count is zero issues no data request. The next bus request is the following instruction fetch.
- R9: Each fetch after the first reads at the previous instruction's address plus 8.
- R10: Opcode 0x98 halts the engine with `irq` high, `err_flag` low and no bus request.
- R11: Every other opcode (0x80–0xFF except 0x98) halts the engine with both `irq` and `err_flag` high.
- R12: `irq_clr` while halted returns the engine to idle on the next cycle, with `irq`, `err_flag` and `busy` low. A later pointer write starts a new script.
- R13: After reset the engine is idle with `bus_req`, `irq`, `err_flag` and `busy` low, and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptr_wr | input | 1 | Script pointer write strobe |
| ptr_wdata | input | 32 | Script start address |
| burst_sel | input | 2 | Burst size select |
| irq_clr | input | 1 | Write-one-to-clear of the interrupt |
| irq | output | 1 | Host interrupt (engine halted) |
| err_flag | output | 1 | Illegal-opcode status |
| busy | output | 1 | Engine is running a script |
| bus_req | output | 1 | Bus request, held for a whole burst or fetch |
| bus_gnt | input | 1 | Bus grant |
| mem_ack | input | 1 | Beat acknowledge |
| mem_addr | output | 32 | Address of the current beat |
| mem_we | output | 1 | Request is a write to memory |
| mem_len | output | 5 | Beats in the current request |
| mem_wdata | output | 32 | Write data (FIFO head) |
| mem_rdata | input | 32 | Read data for an acknowledged beat |
| pf_push | input | 1 | Peripheral push into the FIFO |
| pf_wdata | input | 32 | Peripheral push data |
| pf_full | output | 1 | FIFO full |
| pf_pop | input | 1 | Peripheral pop from the FIFO |
| pf_rdata | output | 32 | FIFO head word |
| pf_empty | output | 1 | FIFO empty |

## Verification
A pointer write is followed by the fetch request in the very next cycle. An acknowledged beat moves the address, the remaining count and the FIFO level one cycle later. After the second fetch beat, the opcode takes effect one cycle later. The FIFO threshold is evaluated in the cycle after a release, so a data request appears no sooner than two cycles after the previous one ended. `irq_clr` takes the engine to idle in the following cycle. The bench drives all inputs and samples all outputs on the falling edge. A behavioural model, advanced on the rising edge from the same inputs, predicts every output for that cycle. Recorded request start addresses and lengths, memory contents and popped words are then compared against lists derived from the requirements.

// File: rtl/sg_dma_pkg.sv
package sg_dma_pkg;

    localparam int ADDR_W    = 32;
    localparam int WORD_W    = 32;
    localparam int CNT_W     = 24;
    localparam int WCNT_W    = CNT_W - 2;
    localparam int MAX_BURST = 16;
    localparam int LEN_W     = $clog2(MAX_BURST + 1);

    localparam logic [7:0] OPC_STOP = 8'h98;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_WAIT,
        ST_BURST,
        ST_HALT
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_RECV,
        OP_SEND,
        OP_STOP,
        OP_BAD
    } op_kind_t;

    typedef struct packed {
        logic [7:0]        opcode;
        logic [WCNT_W-1:0] words;
    } instr_head_t;

    function automatic op_kind_t classify(input logic [7:0] opc);
        op_kind_t k;
        if (opc[7:6] == 2'b00)      k = OP_RECV;
        else if (opc[7:6] == 2'b01) k = OP_SEND;
        else if (opc == OPC_STOP)   k = OP_STOP;
        else                        k = OP_BAD;
        return k;
    endfunction

    function automatic logic [LEN_W-1:0] beats_for(input logic [1:0] sel);
        logic [LEN_W-1:0] b;
        case (sel)
            2'd0:    b = LEN_W'(4);
            2'd1:    b = LEN_W'(8);
            default: b = LEN_W'(MAX_BURST);
        endcase
        return b;
    endfunction

endpackage

// File: rtl/sg_data_fifo.sv
module sg_data_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 32
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           push,
    input  logic [WIDTH-1:0]               wdata,
    input  logic                           pop,
    output logic [WIDTH-1:0]               rdata,
    output logic [$clog2(DEPTH+1)-1:0]     level,
    output logic                           full,
    output logic                           empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] store [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [LW-1:0]    cnt;
    logic             do_push, do_pop;

    assign full    = (cnt == LW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = store[rd_ptr];
    assign level   = cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + AW'(1);
            if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + LW'(1);
                2'b01:   cnt <= cnt - LW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) store[wr_ptr] <= wdata;
    end

endmodule

// File: rtl/sg_burst_plan.sv
module sg_burst_plan
    import sg_dma_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic [1:0]                   burst_sel,
    input  logic [WCNT_W-1:0]            rem_words,
    input  logic [$clog2(DEPTH+1)-1:0]   level,
    input  logic                         to_mem,
    output logic [LEN_W-1:0]             plan_len,
    output logic                         plan_go
);
    logic [LEN_W-1:0]  beats;
    logic [WCNT_W-1:0] beats_ext;
    int                have, room;

    assign beats     = beats_for(burst_sel);
    assign beats_ext = WCNT_W'(beats);
    assign plan_len  = (rem_words < beats_ext) ? rem_words[LEN_W-1:0] : beats;

    always_comb begin
        have    = int'(level);
        room    = DEPTH - int'(level);
        plan_go = to_mem ? (have >= int'(plan_len)) : (room >= int'(plan_len));
    end

endmodule

// File: rtl/sg_dma_seq.sv
module sg_dma_seq
    import sg_dma_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                ptr_wr,
    input  logic [ADDR_W-1:0]   ptr_wdata,
    input  logic                irq_clr,
    input  logic                bus_gnt,
    input  logic                mem_ack,
    input  logic [WORD_W-1:0]   mem_rdata,
    input  logic [LEN_W-1:0]    plan_len,
    input  logic                plan_go,
    output logic                bus_req,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_we,
    output logic [LEN_W-1:0]    mem_len,
    output logic [WCNT_W-1:0]   rem_words,
    output logic                to_mem,
    output logic                eng_push,
    output logic                eng_pop,
    output logic                irq,
    output logic                err_flag,
    output logic                busy
);
    seq_state_t        st;
    logic [ADDR_W-1:0] ptr_q, addr_q;
    logic [WCNT_W-1:0] rem_q;
    logic [LEN_W-1:0]  beat_q, blen_q;
    instr_head_t       head_q;
    logic              to_mem_q, err_q;
    op_kind_t          kind;
    logic              beat_fire, last_beat;

    assign kind      = classify(head_q.opcode);
    assign bus_req   = (st == ST_FETCH) || (st == ST_BURST);
    assign beat_fire = bus_req && bus_gnt && mem_ack;
    assign last_beat = (beat_q == blen_q - LEN_W'(1));

    assign mem_addr  = (st == ST_FETCH) ? ptr_q + ADDR_W'({beat_q, 2'b00}) : addr_q;
    assign mem_we    = (st == ST_BURST) && to_mem_q;
    assign mem_len   = (st == ST_FETCH) ? LEN_W'(2) : blen_q;
    assign rem_words = rem_q;
    assign to_mem    = to_mem_q;
    assign eng_push  = (st == ST_BURST) && !to_mem_q && beat_fire;
    assign eng_pop   = (st == ST_BURST) && to_mem_q && beat_fire;
    assign irq       = (st == ST_HALT);
    assign err_flag  = err_q;
    assign busy      = (st != ST_IDLE) && (st != ST_HALT);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            ptr_q    <= '0;
            addr_q   <= '0;
            rem_q    <= '0;
            beat_q   <= '0;
            blen_q   <= '0;
            head_q   <= '0;
            to_mem_q <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (ptr_wr) begin
                        ptr_q  <= ptr_wdata;
                        beat_q <= '0;
                        st     <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (beat_fire) begin
                        if (beat_q == '0) begin
                            head_q.opcode <= mem_rdata[31:24];
                            head_q.words  <= mem_rdata[CNT_W-1:2];
                            beat_q        <= LEN_W'(1);
                        end else begin
                            addr_q <= mem_rdata;
                            ptr_q  <= ptr_q + ADDR_W'(8);
                            beat_q <= '0;
                            st     <= ST_DECODE;
                        end
                    end
                end
                ST_DECODE: begin
                    case (kind)
                        OP_RECV, OP_SEND: begin
                            to_mem_q <= (kind == OP_RECV);
                            rem_q    <= head_q.words;
                            st       <= (head_q.words == '0) ? ST_FETCH : ST_WAIT;
                        end
                        OP_STOP: st <= ST_HALT;
                        default: begin
                            err_q <= 1'b1;
                            st    <= ST_HALT;
                        end
                    endcase
                end
                ST_WAIT: begin
                    if (rem_q == '0) begin
                        beat_q <= '0;
                        st     <= ST_FETCH;
                    end else if (plan_go) begin
                        blen_q <= plan_len;
                        beat_q <= '0;
                        st     <= ST_BURST;
                    end
                end
                ST_BURST: begin
                    if (beat_fire) begin
                        addr_q <= addr_q + ADDR_W'(4);
                        rem_q  <= rem_q - WCNT_W'(1);
                        if (last_beat) begin
                            beat_q <= '0;
                            st     <= ST_WAIT;
                        end else begin
                            beat_q <= beat_q + LEN_W'(1);
                        end
                    end
                end
                ST_HALT: begin
                    if (irq_clr) begin
                        err_q <= 1'b0;
                        st    <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sg_dma_engine.sv
module sg_dma_engine
    import sg_dma_pkg::*;
#(
    parameter int FIFO_DEPTH = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ptr_wr,
    input  logic [ADDR_W-1:0]   ptr_wdata,
    input  logic [1:0]          burst_sel,
    input  logic                irq_clr,
    output logic                irq,
    output logic                err_flag,
    output logic                busy,
    output logic                bus_req,
    input  logic                bus_gnt,
    input  logic                mem_ack,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_we,
    output logic [LEN_W-1:0]    mem_len,
    output logic [WORD_W-1:0]   mem_wdata,
    input  logic [WORD_W-1:0]   mem_rdata,
    input  logic                pf_push,
    input  logic [WORD_W-1:0]   pf_wdata,
    output logic                pf_full,
    input  logic                pf_pop,
    output logic [WORD_W-1:0]   pf_rdata,
    output logic                pf_empty
);
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

    logic [LVL_W-1:0]  level;
    logic [LEN_W-1:0]  plan_len;
    logic              plan_go;
    logic [WCNT_W-1:0] rem_words;
    logic              to_mem, eng_push, eng_pop;
    logic              f_push, f_pop;
    logic [WORD_W-1:0] f_wdata, f_rdata;

    assign f_push    = eng_push || pf_push;
    assign f_wdata   = eng_push ? mem_rdata : pf_wdata;
    assign f_pop     = eng_pop || pf_pop;
    assign mem_wdata = f_rdata;
    assign pf_rdata  = f_rdata;

    sg_dma_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .ptr_wr    (ptr_wr),
        .ptr_wdata (ptr_wdata),
        .irq_clr   (irq_clr),
        .bus_gnt   (bus_gnt),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .plan_len  (plan_len),
        .plan_go   (plan_go),
        .bus_req   (bus_req),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_len   (mem_len),
        .rem_words (rem_words),
        .to_mem    (to_mem),
        .eng_push  (eng_push),
        .eng_pop   (eng_pop),
        .irq       (irq),
        .err_flag  (err_flag),
        .busy      (busy)
    );

    sg_burst_plan #(.DEPTH(FIFO_DEPTH)) u_plan (
        .burst_sel (burst_sel),
        .rem_words (rem_words),
        .level     (level),
        .to_mem    (to_mem),
        .plan_len  (plan_len),
        .plan_go   (plan_go)
    );

    sg_data_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (f_push),
        .wdata (f_wdata),
        .pop   (f_pop),
        .rdata (f_rdata),
        .level (level),
        .full  (pf_full),
        .empty (pf_empty)
    );

endmodule

// File: rtl/sg_dma_checker.sv
module sg_dma_checker
    import sg_dma_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                ptr_wr,
    input logic [ADDR_W-1:0]   ptr_wdata,
    input logic                irq_clr,
    input logic                irq,
    input logic                err_flag,
    input logic                busy,
    input logic                bus_req,
    input logic                bus_gnt,
    input logic                mem_ack,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic                mem_we,
    input logic [LEN_W-1:0]    mem_len,
    input logic                pf_empty
);
    AST_START_FETCH: assert property (@(posedge clk) disable iff (rst)
        (!busy && !irq && ptr_wr) |=> (bus_req && !mem_we && mem_addr == $past(ptr_wdata) && mem_len == LEN_W'(2))); // R1

    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> (mem_len != '0 && mem_len <= LEN_W'(MAX_BURST))); // R5

    AST_WRITE_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
        (bus_req && mem_we) |-> !pf_empty); // R6

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_gnt && mem_ack) |=> (!bus_req || mem_addr == $past(mem_addr) + ADDR_W'(4))); // R7

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
        irq |-> (!bus_req && !busy)); // R10

    AST_ERR_WITH_IRQ: assert property (@(posedge clk) disable iff (rst)
        err_flag |-> irq); // R11

    AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (rst)
        (irq && irq_clr) |=> (!irq && !err_flag && !busy)); // R12

endmodule

bind sg_dma_engine sg_dma_checker u_chk (.*);

// File: tb/sg_dma_engine_test.sv
module sg_dma_engine_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ptr_wr = 1'b0;
    logic [31:0] ptr_wdata = '0;
    logic [1:0]  burst_sel = '0;
    logic        irq_clr = 1'b0;
    logic        irq, err_flag, busy, bus_req, mem_we, pf_full, pf_empty;
    logic        bus_gnt = 1'b0;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata, pf_rdata;
    logic [31:0] mem_rdata = '0;
    logic [4:0]  mem_len;
    logic        pf_push = 1'b0;
    logic [31:0] pf_wdata = '0;
    logic        pf_pop = 1'b0;

    always #5 clk = ~clk;

    sg_dma_engine uut (
        .clk(clk), .rst(rst), .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata),
        .burst_sel(burst_sel), .irq_clr(irq_clr), .irq(irq), .err_flag(err_flag),
        .busy(busy), .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_ack(mem_ack),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_len(mem_len), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .pf_push(pf_push), .pf_wdata(pf_wdata), .pf_full(pf_full),
        .pf_pop(pf_pop), .pf_rdata(pf_rdata), .pf_empty(pf_empty)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // ---------------- memory and bus responder ----------------
    logic [31:0] mem [logic [31:0]];
    logic [15:0] lfsr = 16'hACE1;
    logic        prev_req = 1'b0;
    logic [31:0] rec_addr[$];
    int          rec_len[$];

    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : ~a;
    endfunction

    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (rst) begin
            bus_gnt = 1'b0;
            mem_ack = 1'b0;
        end else begin
            bus_gnt = bus_req && (lfsr[0] || lfsr[3]);
            mem_ack = bus_gnt && (lfsr[1] || lfsr[5]);
        end
        mem_rdata = mem_rd(mem_addr);
        if (bus_req && bus_gnt && mem_ack && mem_we) mem[mem_addr] = mem_wdata;
        if (!rst && bus_req && !prev_req) begin
            rec_addr.push_back(mem_addr);
            rec_len.push_back(int'(mem_len));
        end
        prev_req = bus_req && !rst;
    end

    // ---------------- peripheral side ----------------
    bit          push_en = 0, pop_en = 0;
    int          push_idx = 0, push_total = 0;
    logic [31:0] popped[$];

    always @(negedge clk) begin
        pf_push = push_en && (push_idx < push_total) && !pf_full && (cyc % 4 == 0);
        pf_wdata = 32'hA000_0000 + push_idx;
        if (pf_push) push_idx++;
        pf_pop = pop_en && !pf_empty && (cyc % 3 == 0);
        if (pf_pop) popped.push_back(pf_rdata);
    end

    // ---------------- behavioural reference model ----------------
    localparam int M_IDLE = 0, M_FETCH = 1, M_DEC = 2, M_WAIT = 3, M_BURST = 4, M_HALT = 5;
    int          m_st = M_IDLE;
    logic [31:0] m_ptr = 0, m_addr = 0;
    int          m_rem = 0, m_beat = 0, m_blen = 0, m_cnt = 0;
    logic [7:0]  m_opc = 0;
    bit          m_recv = 0, m_err = 0;
    logic [31:0] m_q[$];

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_st = M_IDLE; m_err = 0; m_q.delete();
        end else begin
            int  n;
            bit  fire, e_push, e_pop, do_push, do_pop, mreq;
            logic [31:0] pv;
            n     = m_q.size();
            mreq  = (m_st == M_FETCH) || (m_st == M_BURST);
            fire  = mreq && bus_gnt && mem_ack;
            e_push = (m_st == M_BURST) && fire && !m_recv;
            e_pop  = (m_st == M_BURST) && fire && m_recv;
            do_push = e_push || (pf_push && n < 32);
            do_pop  = e_pop || (pf_pop && n > 0);
            pv = e_push ? mem_rdata : pf_wdata;
            if (do_pop) void'(m_q.pop_front());
            if (do_push) m_q.push_back(pv);
            case (m_st)
                M_IDLE: if (ptr_wr) begin m_ptr = ptr_wdata; m_beat = 0; m_st = M_FETCH; end
                M_FETCH: if (fire) begin
                    if (m_beat == 0) begin
                        m_opc = mem_rdata[31:24]; m_cnt = int'(mem_rdata[23:2]); m_beat = 1;
                    end else begin
                        m_addr = mem_rdata; m_ptr = m_ptr + 8; m_beat = 0; m_st = M_DEC;
                    end
                end
                M_DEC: begin
                    if (m_opc < 8'h80) begin
                        m_recv = (m_opc < 8'h40); m_rem = m_cnt;
                        m_st = (m_cnt == 0) ? M_FETCH : M_WAIT;
                    end else begin
                        if (m_opc != 8'h98) m_err = 1;
                        m_st = M_HALT;
                    end
                end
                M_WAIT: begin
                    int bl, len;
                    bl  = (burst_sel == 0) ? 4 : (burst_sel == 1) ? 8 : 16;
                    len = (m_rem < bl) ? m_rem : bl;
                    if (m_rem == 0) begin m_beat = 0; m_st = M_FETCH; end
                    else if (m_recv ? (n >= len) : (32 - n >= len)) begin
                        m_blen = len; m_beat = 0; m_st = M_BURST;
                    end
                end
                M_BURST: if (fire) begin
                    m_addr = m_addr + 4; m_rem--;
                    if (m_beat == m_blen - 1) begin m_beat = 0; m_st = M_WAIT; end
                    else m_beat++;
                end
                default: if (irq_clr) begin m_err = 0; m_st = M_IDLE; end
            endcase
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit e_req, e_we;
            e_req = (m_st == M_FETCH) || (m_st == M_BURST);
            e_we  = (m_st == M_BURST) && m_recv;
            chk(bus_req == e_req, "R6", "bus_req", 32'(bus_req), 32'(e_req));
            if (e_req) begin
                chk(mem_addr == ((m_st == M_FETCH) ? m_ptr + 32'(m_beat * 4) : m_addr),
                    "R7", "mem_addr", mem_addr, (m_st == M_FETCH) ? m_ptr + 32'(m_beat * 4) : m_addr);
                chk(int'(mem_len) == ((m_st == M_FETCH) ? 2 : m_blen), "R5", "mem_len",
                    32'(mem_len), 32'((m_st == M_FETCH) ? 2 : m_blen));
                chk(mem_we == e_we, "R3", "mem_we", 32'(mem_we), 32'(e_we));
                if (e_we && m_q.size() > 0) chk(mem_wdata == m_q[0], "R3", "mem_wdata", mem_wdata, m_q[0]);
            end
            chk(irq == (m_st == M_HALT), "R10", "irq", 32'(irq), 32'(m_st == M_HALT));
            chk(err_flag == m_err, "R11", "err_flag", 32'(err_flag), 32'(m_err));
            chk(busy == (m_st != M_IDLE && m_st != M_HALT), "R12", "busy", 32'(busy),
                32'(m_st != M_IDLE && m_st != M_HALT));
            chk(pf_empty == (m_q.size() == 0), "R13", "pf_empty", 32'(pf_empty), 32'(m_q.size() == 0));
            if (m_q.size() > 0) chk(pf_rdata == m_q[0], "R4", "pf_rdata", pf_rdata, m_q[0]);
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            done = 1;
            failures++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    logic [31:0] exp_a[$];
    int          exp_l[$];

    task automatic start_script(input logic [31:0] a, input logic [1:0] sel);
        burst_sel = sel;
        rec_addr.delete(); rec_len.delete();
        ptr_wdata = a; ptr_wr = 1'b1;
        @(negedge clk);
        ptr_wr = 1'b0;
        chk(bus_req && !mem_we && mem_addr == a && mem_len == 5'd2, "R1", "fetch start",
            mem_addr, a);
    endtask

    task automatic wait_halt();
        int k = 0;
        while (!irq && k < 20000) begin @(negedge clk); k++; end
        chk(irq, "R10", "halt reached", 32'(irq), 32'd1);
    endtask

    task automatic check_starts(input string tag);
        chk(rec_addr.size() == exp_a.size(), tag, "request count", rec_addr.size(), exp_a.size());
        foreach (exp_a[i]) begin
            if (i < rec_addr.size()) begin
                chk(rec_addr[i] == exp_a[i], tag, "request address", rec_addr[i], exp_a[i]);
                chk(rec_len[i] == exp_l[i], tag, "request length", rec_len[i], exp_l[i]);
            end
        end
    endtask

    task automatic clear_irq();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        chk(!irq && !err_flag && !busy, "R12", "idle after clear",
            {29'd0, irq, err_flag, busy}, 32'd0);
    endtask

    initial begin
        // script 1: two receives, a zero-count move, then stop
        mem[32'h100] = 32'h0000_0018; mem[32'h104] = 32'h0000_2000;
        mem[32'h108] = 32'h3F00_0000; mem[32'h10C] = 32'h0000_2800;
        mem[32'h110] = 32'h0000_000B; mem[32'h114] = 32'h0000_2100;
        mem[32'h118] = 32'h9800_0000; mem[32'h11C] = 32'h0000_0000;
        // script 2: one long send, then stop
        mem[32'h200] = 32'h4000_00C0; mem[32'h204] = 32'h0000_3000;
        mem[32'h208] = 32'h9800_0000; mem[32'h20C] = 32'h0000_0000;
        // script 3: short send, then illegal opcode
        mem[32'h300] = 32'h4000_002C; mem[32'h304] = 32'h0000_3000;
        mem[32'h308] = 32'h8000_0000; mem[32'h30C] = 32'h0000_0000;
        for (int i = 0; i < 48; i++) mem[32'h3000 + 32'(i * 4)] = 32'h5000_0000 + 32'(i);

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!bus_req && !irq && !err_flag && !busy && pf_empty, "R13", "reset state",
            {27'd0, bus_req, irq, err_flag, busy, pf_empty}, 32'd1);

        // ---- script 1, bursts of 4 ----
        push_total = 8; push_idx = 0; push_en = 1;
        start_script(32'h100, 2'd0);
        wait_halt();
        chk(!err_flag, "R10", "stop without error", 32'(err_flag), 32'd0);
        exp_a = '{32'h100, 32'h2000, 32'h2010, 32'h108, 32'h110, 32'h2100, 32'h118};
        exp_l = '{2, 4, 2, 2, 2, 2, 2};
        check_starts("R2/R5/R8/R9");
        for (int i = 0; i < 6; i++)
            chk(mem_rd(32'h2000 + 32'(i * 4)) == 32'hA000_0000 + 32'(i), "R3", "scatter word",
                mem_rd(32'h2000 + 32'(i * 4)), 32'hA000_0000 + 32'(i));
        chk(mem_rd(32'h2100) == 32'hA000_0006, "R3", "second move w0", mem_rd(32'h2100), 32'hA000_0006);
        chk(mem_rd(32'h2104) == 32'hA000_0007, "R3", "second move w1", mem_rd(32'h2104), 32'hA000_0007);
        chk(!mem.exists(32'h2108), "R3", "partial word dropped", 32'(mem.exists(32'h2108)), 32'd0);
        chk(!mem.exists(32'h2800), "R8", "zero move untouched", 32'(mem.exists(32'h2800)), 32'd0);
        push_en = 0;
        // pointer write while halted is ignored
        ptr_wdata = 32'h400; ptr_wr = 1'b1;
        @(negedge clk);
        ptr_wr = 1'b0;
        @(negedge clk);
        chk(irq && !bus_req, "R1", "write ignored while halted", {30'd0, irq, bus_req}, 32'd2);
        clear_irq();

        // ---- script 2, bursts of 16, FIFO space gates the third ----
        popped.delete(); pop_en = 1;
        start_script(32'h200, 2'd2);
        wait_halt();
        chk(!err_flag, "R10", "stop without error", 32'(err_flag), 32'd0);
        exp_a = '{32'h200, 32'h3000, 32'h3040, 32'h3080, 32'h208};
        exp_l = '{2, 16, 16, 16, 2};
        check_starts("R5/R6/R9");
        begin
            int k = 0;
            while (popped.size() < 48 && k < 2000) begin @(negedge clk); k++; end
        end
        chk(popped.size() == 48, "R4", "gathered count", popped.size(), 32'd48);
        foreach (popped[i])
            chk(popped[i] == 32'h5000_0000 + 32'(i), "R4", "gathered word", popped[i], 32'h5000_0000 + 32'(i));
        clear_irq();

        // ---- script 3, bursts of 8, then illegal opcode ----
        popped.delete();
        start_script(32'h300, 2'd1);
        wait_halt();
        chk(err_flag, "R11", "illegal opcode error", 32'(err_flag), 32'd1);
        exp_a = '{32'h300, 32'h3000, 32'h3020, 32'h308};
        exp_l = '{2, 8, 3, 2};
        check_starts("R5/R9/R11");
        begin
            int k = 0;
            while (popped.size() < 11 && k < 2000) begin @(negedge clk); k++; end
        end
        chk(popped.size() == 11, "R4", "short send count", popped.size(), 32'd11);
        pop_en = 0;
        clear_irq();

        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule